// File: doc/BRIEF.md
# Interrupt Identity, Mask and Enable Controller

This block gathers single-cycle event pulses from a set of interrupt sources and records them in a sticky identity register. Typical sources are two display pipes, a command-stream completion event and a firmware request. A source can only reach the identity register when it passes two gates. The first is an enable register, which decides whether the source takes part at all. The second is a mask register, in which a 1 blocks the source. Some sources are marked by a build-time parameter as permanently unmasked. These sources skip the mask gate, because their gating is done further upstream, but they still need their enable bit.

Software reaches four registers through a simple write-strobe port with a combinational read path. Software clears the identity register by writing 1s to it: writing back the value it read clears exactly those bits. The block drives a level interrupt that is high while any identity bit is set. When the message-signalled mode input is high, the level line is held low. Instead, a one-clock message pulse fires when the identity register goes from all-zero to non-zero. An event that arrives while other bits are still pending therefore sends no new message. Software must re-read the register and loop until it reads zero. Clearing the register back to zero arms the next message.

Top module: `irq_ident_ctrl`

## Requirements
- R1: After reset the identity register reads 0, enable reads 0, mask reads all ones, the spare status-mask register reads all ones, and both outputs are low.
- R2: A pulse on `src_evt[i]` sets identity bit i at the next clock edge only when enable bit i is 1 and mask bit i is 0 (mask 1 = blocked). Otherwise the identity register is unchanged.
- R3: A source whose bit is set in parameter `ALWAYS_ON` (default 8'h03, bits 0 and 1) ignores its mask bit but still requires its enable bit.
- R4: A write to address 0 clears exactly the identity bits written as 1. Bits written as 0 are unaffected.
- R5: When a source event and a clearing write hit the same identity bit in one cycle, the bit stays set.
- R6: Identity bits are sticky. Later changes to enable or mask do not clear them.
- R7: With `msi_en` = 0, `irq_level` is high exactly while the identity register is non-zero. With `msi_en` = 1, `irq_level` stays low.
- R8: With `msi_en` = 1, `msg_pulse` is high for exactly one clock, starting at the edge where the identity register goes from zero to non-zero. It does not fire when bits are added to a non-zero register, and it never fires with `msi_en` = 0.
- R9: Once the identity register has been cleared to zero, the next accepted event produces a new message pulse.
- R10: Register addresses are: 0 identity, 1 enable, 2 mask, 3 status mask. Enable, mask and status mask read back the last value written.
- R11: An event that lands in the same cycle as a write clearing all other pending bits leaves the register non-zero and produces no message pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en | input | 1 | Message-signalled mode select |
| src_evt | input | N | One-cycle event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data of the selected register (combinational) |
| irq_level | output | 1 | Level interrupt, active while any identity bit is set (non-message mode) |
| msg_pulse | output | 1 | One-clock message request on the zero-to-non-zero transition |

## Verification
The assertions assume three things about the inputs:
- `src_evt` bits are single-cycle pulses sampled at the clock edge.
- `msi_en` changes only while the identity register is empty or between checks.
- A write strobe addresses one register per cycle.

The stimulus follows these rules. It drives every input one time unit after a rising edge and returns pulses to zero after one edge. It toggles the mode only when the register is cleared. The collision cases, a clear landing together with an event on the same or a different bit, are produced deliberately within these rules.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
   typedef enum logic [1:0] {
      SEL_IDENT  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_SMASK  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [1:0]   addr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] enable_q,
   output logic [N-1:0] mask_q,
   output logic [N-1:0] smask_q
);
   import irq_ident_pkg::*;

   localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         mask_q   <= ALL_ONES;
         smask_q  <= ALL_ONES;
      end else if (wr) begin
         case (reg_sel_e'(addr))
            SEL_ENABLE: enable_q <= wdata;
            SEL_MASK:   mask_q   <= wdata;
            SEL_SMASK:  smask_q  <= wdata;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/irq_ident_reg.sv
module irq_ident_reg #(
   parameter int           N         = 8,
   parameter logic [N-1:0] ALWAYS_ON = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_evt,
   input  logic [N-1:0] enable,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] set_vec,
   output logic [N-1:0] ident_q
);
   // per-source gate: permanently unmasked sources skip the mask
   for (genvar i = 0; i < N; i++) begin : g_gate
      if (ALWAYS_ON[i]) begin : g_fixed
         assign set_vec[i] = src_evt[i] & enable[i];
      end else begin : g_masked
         assign set_vec[i] = src_evt[i] & enable[i] & ~mask[i];
      end
   end

   // a new event wins over a clearing write of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ident_q <= '0;
      else        ident_q <= (ident_q & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         msi_en,
   input  logic [N-1:0] ident_q,
   input  logic [N-1:0] set_vec,
   output logic         msg_pulse
);
   logic arm;
   // from an empty register a clear cannot matter, so any set makes it non-zero
   assign arm = msi_en && (ident_q == '0) && (set_vec != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msg_pulse <= 1'b0;
      else        msg_pulse <= arm;
   end
endmodule

// File: rtl/irq_ident_ctrl.sv
module irq_ident_ctrl #(
   parameter int           N         = 8,
   parameter logic [N-1:0] ALWAYS_ON = 8'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         msi_en,
   input  logic [N-1:0] src_evt,
   input  logic         reg_wr,
   input  logic [1:0]   reg_addr,
   input  logic [N-1:0] reg_wdata,
   output logic [N-1:0] reg_rdata,
   output logic         irq_level,
   output logic         msg_pulse
);
   import irq_ident_pkg::*;

   if (N < 1 || N > 32) begin : g_bad_width
      $error("irq_ident_ctrl: N must lie in 1..32");
   end

   logic [N-1:0] enable_q, mask_q, smask_q, ident_q, set_vec, clr_vec;

   irq_cfg_regs #(.N(N)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .enable_q(enable_q), .mask_q(mask_q), .smask_q(smask_q)
   );

   assign clr_vec = (reg_wr && reg_addr == SEL_IDENT) ? reg_wdata : '0;

   irq_ident_reg #(.N(N), .ALWAYS_ON(ALWAYS_ON)) u_ident (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .enable(enable_q),
      .mask(mask_q), .clr_vec(clr_vec), .set_vec(set_vec), .ident_q(ident_q)
   );

   irq_msg_gen #(.N(N)) u_msg (
      .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .ident_q(ident_q),
      .set_vec(set_vec), .msg_pulse(msg_pulse)
   );

   assign irq_level = (ident_q != '0) && !msi_en;

   always_comb begin
      case (reg_sel_e'(reg_addr))
         SEL_IDENT:  reg_rdata = ident_q;
         SEL_ENABLE: reg_rdata = enable_q;
         SEL_MASK:   reg_rdata = mask_q;
         default:    reg_rdata = smask_q;
      endcase
   end
endmodule

// File: rtl/irq_ident_ctrl_chk.sv
module irq_ident_ctrl_chk #(
   parameter int           N         = 8,
   parameter logic [N-1:0] ALWAYS_ON = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         msi_en,
   input logic [N-1:0] src_evt,
   input logic         reg_wr,
   input logic [1:0]   reg_addr,
   input logic [N-1:0] reg_wdata,
   input logic [N-1:0] enable_q,
   input logic [N-1:0] mask_q,
   input logic [N-1:0] ident_q,
   input logic         msg_pulse
);
   logic [N-1:0] accept, clr;
   assign accept = src_evt & enable_q & ~(mask_q & ~ALWAYS_ON);
   assign clr    = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;

   // R2: no identity bit rises without an accepted event
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ((ident_q & ~$past(ident_q)) & ~$past(accept)) == '0);

   // R5: accepted events always land, even against a clear
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (accept != '0) |=> ((ident_q & $past(accept)) == $past(accept)));

   // R6: pending bits only fall under a clearing write
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ident_q & $past(ident_q & ~clr)) == $past(ident_q & ~clr));

   // R8: message lasts one clock
   a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |=> !msg_pulse);

   // R8: message only on zero-to-non-zero in message mode
   a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> (ident_q != '0 && $past(ident_q) == '0 && $past(msi_en)));
endmodule

bind irq_ident_ctrl irq_ident_ctrl_chk #(.N(N), .ALWAYS_ON(ALWAYS_ON)) u_chk (
   .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .src_evt(src_evt),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .enable_q(enable_q), .mask_q(mask_q), .ident_q(ident_q),
   .msg_pulse(msg_pulse)
);

// File: tb/sim_irq_ident_ctrl.sv
module sim_irq_ident_ctrl;
   localparam int       N  = 8;
   localparam logic [7:0] AO = 8'h03;

   logic clk = 0, rst_n = 0, msi_en = 0, reg_wr = 0;
   logic [N-1:0] src_evt = '0, reg_wdata = '0, reg_rdata;
   logic [1:0]   reg_addr = '0;
   logic irq_level, msg_pulse;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_ident_ctrl #(.N(N), .ALWAYS_ON(AO)) u0 (
      .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .src_evt(src_evt),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_level(irq_level), .msg_pulse(msg_pulse)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a; #1; v = int'(reg_rdata);
   endtask

   task automatic fire(input logic [N-1:0] v);
      src_evt = v;
      step();
      src_evt = '0;
   endtask

   initial begin
      int v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      step();
      // R1 reset state
      rd(0, v); check("R1 ident", v, 0);
      rd(1, v); check("R1 enable", v, 0);
      rd(2, v); check("R1 mask", v, 8'hFF);
      rd(3, v); check("R1 smask", v, 8'hFF);
      check("R1 level", int'(irq_level), 0);
      check("R1 msg", int'(msg_pulse), 0);

      // R10 readback
      wr(1, 8'hA5); rd(1, v); check("R10 enable", v, 8'hA5);
      wr(2, 8'h5A); rd(2, v); check("R10 mask", v, 8'h5A);
      wr(3, 8'hEF); rd(3, v); check("R10 smask", v, 8'hEF);

      // R2 / R3 sweep over every source, enable and mask
      for (int i = 0; i < N; i++) begin
         for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 2; m++) begin
               int exp;
               wr(0, 8'hFF);
               wr(1, e ? (8'h01 << i) : 8'h00);
               wr(2, m ? 8'hFF : 8'h00);
               fire(8'h01 << i);
               exp = (e == 1 && (m == 0 || AO[i])) ? (1 << i) : 0;
               rd(0, v);
               check(AO[i] ? "R3 fixed gate" : "R2 gate", v, exp);
            end
         end
      end

      // R6 sticky
      wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'h00);
      fire(8'h30);
      wr(1, 8'h00); wr(2, 8'hFF);
      rd(0, v); check("R6 sticky", v, 8'h30);

      // R4 write-one-to-clear
      wr(0, 8'h10); rd(0, v); check("R4 partial", v, 8'h20);
      wr(0, 8'h0F); rd(0, v); check("R4 zeros", v, 8'h20);
      wr(0, 8'hFF); rd(0, v); check("R4 all", v, 0);

      // R7 level
      wr(1, 8'hFF); wr(2, 8'h00);
      msi_en = 0;
      fire(8'h04);
      check("R7 level high", int'(irq_level), 1);
      check("R8 no msg level mode", int'(msg_pulse), 0);
      wr(0, 8'h04);
      check("R7 level low", int'(irq_level), 0);
      msi_en = 1;
      fire(8'h04);
      check("R7 level quiet msi", int'(irq_level), 0);
      check("R8 msg first", int'(msg_pulse), 1);
      step();
      check("R8 msg one clock", int'(msg_pulse), 0);
      fire(8'h08);
      check("R8 no msg when pending", int'(msg_pulse), 0);
      rd(0, v); check("R8 ident", v, 8'h0C);

      // R11 new bit against full clear
      reg_wr = 1; reg_addr = 0; reg_wdata = 8'h0C; src_evt = 8'h40;
      step();
      reg_wr = 0; src_evt = '0;
      check("R11 no msg", int'(msg_pulse), 0);
      rd(0, v); check("R11 pending", v, 8'h40);

      // R5 same-bit collision
      reg_wr = 1; reg_addr = 0; reg_wdata = 8'h40; src_evt = 8'h40;
      step();
      reg_wr = 0; src_evt = '0;
      rd(0, v); check("R5 set wins", v, 8'h40);

      // R9 re-arm
      wr(0, 8'hFF);
      fire(8'h80);
      check("R9 rearmed msg", int'(msg_pulse), 1);
      rd(0, v); check("R9 ident", v, 8'h80);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule